// File: doc/BRIEF.md
# Threshold-Flagged Transmit/Receive Byte Queue Pair

This block holds two byte queues between a register bus and a serial engine. The bus side writes bytes into the transmit queue and reads bytes out of the receive queue. The engine side pops the transmit queue and pushes into the receive queue. Each queue holds up to 15 bytes.

Each queue has a threshold that software can program, and a set of level flags for an interrupt unit. The transmit side reports empty, nearly empty, full and overrun. The receive side reports empty, nearly full and full. A write to the control word can request a flush of either queue. The requested flush bit then reads back as set while the flush runs, which takes a fixed number of cycles. When the flush finishes, the bit clears itself and the queue is left empty. While a queue is being flushed, no access to it takes effect.

Top module: `txrx_fifo_pair`

## Requirements
- R1: After reset both queues are empty. `tx_empty_o`, `tx_nempty_o` and `rx_empty_o` are 1. `tx_full_o`, `rx_full_o`, `tx_ovr_o` and `ctrl_rdata_o` are 0. `rx_nfull_o` is 0 whenever `rx_thr_i` is greater than 0.
- R2: Each queue returns bytes in the order they were accepted. `tx_data_o` and `rx_rdata_o` show the oldest byte, and each accepted pop or read at a clock edge moves to the next byte.
- R3: A queue reports full when it holds 15 bytes and empty when it holds none. A push into a full queue is dropped.
- R4: `tx_nempty_o` is 1 exactly when the transmit byte count is less than or equal to `tx_thr_i` (0 to 15).
- R5: `rx_nfull_o` is 1 exactly when the receive byte count is greater than or equal to `rx_thr_i` (0 to 15).
- R6: A bus write to the transmit queue while it is full drops the byte and sets `tx_ovr_o` from the next cycle on. The flag stays 1 until `tx_ovr_clr_i` is pulsed.
- R7: A control write with bit 7 set starts a transmit flush, and one with bit 8 set starts a receive flush. The same bit of `ctrl_rdata_o` reads 1 for exactly 4 cycles after the write edge. It then reads 0, and the queue is empty. Other bits of `ctrl_rdata_o` read 0.
- R8: While a queue is being flushed, pushes, pops, reads and further flush requests for that queue have no effect, and no overrun is raised. The other queue keeps working normally.
- R9: Reading an empty receive queue returns 0 on `rx_rdata_o` and changes nothing. A pop of an empty transmit queue is ignored, and `tx_data_o` shows 0 while that queue is empty.
- R10: A push and a pop in the same cycle leave the byte count unchanged and keep the order. If the transmit queue is full, a write that comes with a pop is still dropped and flagged as an overrun, while the pop still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_thr_i | input | 4 | Transmit nearly-empty threshold |
| rx_thr_i | input | 4 | Receive nearly-full threshold |
| ctrl_wr_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 16 | Control word; bit 7 flushes TX, bit 8 flushes RX |
| ctrl_rdata_o | output | 16 | Control read-back; flush bits while busy |
| tx_wr_i | input | 1 | Bus write into transmit queue |
| tx_wdata_i | input | 8 | Bus write byte |
| rx_rd_i | input | 1 | Bus read from receive queue |
| rx_rdata_o | output | 8 | Oldest receive byte, 0 when empty |
| tx_pop_i | input | 1 | Engine pop from transmit queue |
| tx_data_o | output | 8 | Oldest transmit byte, 0 when empty |
| rx_push_i | input | 1 | Engine push into receive queue |
| rx_din_i | input | 8 | Engine receive byte |
| tx_ovr_clr_i | input | 1 | Clears the overrun flag |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_nempty_o | output | 1 | Transmit count at or below threshold |
| tx_full_o | output | 1 | Transmit queue full |
| tx_ovr_o | output | 1 | Sticky transmit overrun |
| rx_empty_o | output | 1 | Receive queue empty |
| rx_nfull_o | output | 1 | Receive count at or above threshold |
| rx_full_o | output | 1 | Receive queue full |

## Verification
Two collisions get the closest attention. The first is a push and a pop on the same queue in one cycle, in particular a bus write to a full transmit queue together with an engine pop. The bench produces it by filling the queue to 15 and then raising both strobes at once. It passes only if the overrun flag sets, the write is dropped, the head moves on by one, and the drained sequence holds neither dropped byte. The second is a flush of one queue while the other queue is in use, with accesses and a repeated flush request aimed at the busy queue. The bench passes only if the busy queue's head stays frozen, the flush bit still clears on the fourth cycle, and the idle queue's data moves as it would without the flush.

// File: rtl/hfx_pkg.sv
package hfx_pkg;
  localparam int FLUSH_TX_BIT = 7;
  localparam int FLUSH_RX_BIT = 8;
  localparam int NUM_CH       = 2;
  localparam int CH_TX        = 0;
  localparam int CH_RX        = 1;
endpackage

// File: rtl/hfx_byte_fifo.sv
module hfx_byte_fifo #(
  parameter int DEPTH = 15,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  input  logic          clr_i,
  output logic [DW-1:0] dout_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (count_o == '0);
  assign full_o  = (count_o == CW'(DEPTH));
  assign do_push = push_i && !full_o && !clr_i;
  assign do_pop  = pop_i && !empty_o && !clr_i;
  assign dout_o  = empty_o ? '0 : mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else if (clr_i) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));

  // R2
  push_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o && !pop_i && !clr_i) |=> (count_o == $past(count_o) + CW'(1)));

  // R9
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i && !clr_i) |=> $stable(count_o));
endmodule

// File: rtl/hfx_flush_timer.sv
module hfx_flush_timer #(
  parameter int FLUSH_CYC = 4,
  localparam int TW = (FLUSH_CYC > 1) ? $clog2(FLUSH_CYC) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic busy_o,
  output logic done_o
);
  logic [TW-1:0] cnt_q;

  assign done_o = busy_o && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_o) begin
      if (req_i) begin
        busy_o <= 1'b1;
        cnt_q  <= TW'(FLUSH_CYC - 1);
      end
    end else if (done_o) begin
      busy_o <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R8
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
endmodule

// File: rtl/txrx_fifo_pair.sv
module txrx_fifo_pair
  import hfx_pkg::*;
#(
  parameter int DEPTH     = 15,
  parameter int DW        = 8,
  parameter int THR_W     = 4,
  parameter int CTRL_W    = 16,
  parameter int FLUSH_CYC = 4,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [THR_W-1:0]  tx_thr_i,
  input  logic [THR_W-1:0]  rx_thr_i,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [CTRL_W-1:0] ctrl_rdata_o,
  input  logic              tx_wr_i,
  input  logic [DW-1:0]     tx_wdata_i,
  input  logic              rx_rd_i,
  output logic [DW-1:0]     rx_rdata_o,
  input  logic              tx_pop_i,
  output logic [DW-1:0]     tx_data_o,
  input  logic              rx_push_i,
  input  logic [DW-1:0]     rx_din_i,
  input  logic              tx_ovr_clr_i,
  output logic              tx_empty_o,
  output logic              tx_nempty_o,
  output logic              tx_full_o,
  output logic              tx_ovr_o,
  output logic              rx_empty_o,
  output logic              rx_nfull_o,
  output logic              rx_full_o
);
  logic [NUM_CH-1:0] fl_req, fl_busy, fl_done;
  logic [CW-1:0]     tx_cnt, rx_cnt;
  logic              ctrl_unused;

  // bits outside the two flush fields carry no function
  assign ctrl_unused = ^ctrl_wdata_i;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_flush
    localparam int FBIT = (g == CH_TX) ? FLUSH_TX_BIT : FLUSH_RX_BIT;
    assign fl_req[g] = ctrl_wr_i && ctrl_wdata_i[FBIT];
    hfx_flush_timer #(.FLUSH_CYC(FLUSH_CYC)) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (fl_req[g]),
      .busy_o (fl_busy[g]),
      .done_o (fl_done[g])
    );
  end

  always_comb begin
    ctrl_rdata_o               = '0;
    ctrl_rdata_o[FLUSH_TX_BIT] = fl_busy[CH_TX];
    ctrl_rdata_o[FLUSH_RX_BIT] = fl_busy[CH_RX];
  end

  hfx_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (tx_wr_i && !fl_busy[CH_TX]),
    .din_i   (tx_wdata_i),
    .pop_i   (tx_pop_i && !fl_busy[CH_TX]),
    .clr_i   (fl_done[CH_TX]),
    .dout_o  (tx_data_o),
    .count_o (tx_cnt),
    .empty_o (tx_empty_o),
    .full_o  (tx_full_o)
  );

  hfx_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_push_i && !fl_busy[CH_RX]),
    .din_i   (rx_din_i),
    .pop_i   (rx_rd_i && !fl_busy[CH_RX]),
    .clr_i   (fl_done[CH_RX]),
    .dout_o  (rx_rdata_o),
    .count_o (rx_cnt),
    .empty_o (rx_empty_o),
    .full_o  (rx_full_o)
  );

  assign tx_nempty_o = 32'(tx_cnt) <= 32'(tx_thr_i);
  assign rx_nfull_o  = 32'(rx_cnt) >= 32'(rx_thr_i);

  // set wins over clear so a same-cycle overrun is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                      tx_ovr_o <= 1'b0;
    else if (tx_wr_i && tx_full_o && !fl_busy[CH_TX]) tx_ovr_o <= 1'b1;
    else if (tx_ovr_clr_i)                            tx_ovr_o <= 1'b0;
  end

  // R6
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_wr_i && tx_full_o && !fl_busy[CH_TX]) |=> tx_ovr_o);

  // R7
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fl_busy[CH_TX]) |-> (tx_empty_o && tx_cnt == '0));

  // R8
  flush_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_busy[CH_RX] && !fl_done[CH_RX]) |=> $stable(rx_cnt));
endmodule

// File: tb/txrx_fifo_pair_tb.sv
module txrx_fifo_pair_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  tx_thr = 4'd1, rx_thr = 4'd2;
  logic        ctrl_wr = 1'b0;
  logic [15:0] ctrl_wdata = '0, ctrl_rdata;
  logic        tx_wr = 1'b0, rx_rd = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, ovr_clr = 1'b0;
  logic [7:0]  tx_wdata = '0, rx_din = '0, rx_rdata, tx_data;
  logic        tx_empty, tx_nempty, tx_full, tx_ovr, rx_empty, rx_nfull, rx_full;
  int          n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  txrx_fifo_pair u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_thr_i(tx_thr), .rx_thr_i(rx_thr),
    .ctrl_wr_i(ctrl_wr), .ctrl_wdata_i(ctrl_wdata), .ctrl_rdata_o(ctrl_rdata),
    .tx_wr_i(tx_wr), .tx_wdata_i(tx_wdata), .rx_rd_i(rx_rd), .rx_rdata_o(rx_rdata),
    .tx_pop_i(tx_pop), .tx_data_o(tx_data), .rx_push_i(rx_push), .rx_din_i(rx_din),
    .tx_ovr_clr_i(ovr_clr), .tx_empty_o(tx_empty), .tx_nempty_o(tx_nempty),
    .tx_full_o(tx_full), .tx_ovr_o(tx_ovr), .rx_empty_o(rx_empty),
    .rx_nfull_o(rx_nfull), .rx_full_o(rx_full)
  );

  typedef struct packed {
    logic twr; logic [7:0] td; logic tpop; logic [7:0] eth; logic ete; logic etne;
    logic rpush; logic [7:0] rdi; logic rrd; logic [7:0] erh; logic ere; logic ernf;
  } vec_t;

  // tx threshold 1, rx threshold 2
  localparam vec_t VEC [11] = '{
    '{1'b1,8'hA1,1'b0, 8'hA1,1'b0,1'b1, 1'b1,8'h11,1'b0, 8'h11,1'b0,1'b0},
    '{1'b1,8'hB2,1'b0, 8'hA1,1'b0,1'b0, 1'b1,8'h22,1'b0, 8'h11,1'b0,1'b1},
    '{1'b1,8'hC3,1'b1, 8'hB2,1'b0,1'b0, 1'b1,8'h33,1'b1, 8'h22,1'b0,1'b1},
    '{1'b0,8'h00,1'b1, 8'hC3,1'b0,1'b1, 1'b0,8'h00,1'b1, 8'h33,1'b0,1'b0},
    '{1'b0,8'h00,1'b1, 8'h00,1'b1,1'b1, 1'b0,8'h00,1'b1, 8'h00,1'b1,1'b0},
    '{1'b0,8'h00,1'b1, 8'h00,1'b1,1'b1, 1'b0,8'h00,1'b1, 8'h00,1'b1,1'b0},
    '{1'b1,8'hD4,1'b1, 8'hD4,1'b0,1'b1, 1'b1,8'h44,1'b1, 8'h44,1'b0,1'b0},
    '{1'b1,8'hE5,1'b0, 8'hD4,1'b0,1'b0, 1'b0,8'h00,1'b0, 8'h44,1'b0,1'b0},
    '{1'b0,8'h00,1'b0, 8'hD4,1'b0,1'b0, 1'b1,8'h55,1'b0, 8'h44,1'b0,1'b1},
    '{1'b0,8'h00,1'b1, 8'hE5,1'b0,1'b1, 1'b0,8'h00,1'b1, 8'h55,1'b0,1'b0},
    '{1'b0,8'h00,1'b1, 8'h00,1'b1,1'b1, 1'b0,8'h00,1'b1, 8'h00,1'b1,1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    ctrl_wr = 0; ctrl_wdata = '0; tx_wr = 0; tx_pop = 0; rx_rd = 0; rx_push = 0; ovr_clr = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check("R1 tx_empty", tx_empty, 1); check("R1 tx_nempty", tx_nempty, 1);
    check("R1 tx_full", tx_full, 0);   check("R1 tx_ovr", tx_ovr, 0);
    check("R1 rx_empty", rx_empty, 1); check("R1 rx_nfull", rx_nfull, 0);
    check("R1 rx_full", rx_full, 0);   check("R1 ctrl", ctrl_rdata, 0);

    // R2 R4 R5 R9 R10 vector walk
    foreach (VEC[i]) begin
      tx_wr = VEC[i].twr; tx_wdata = VEC[i].td; tx_pop = VEC[i].tpop;
      rx_push = VEC[i].rpush; rx_din = VEC[i].rdi; rx_rd = VEC[i].rrd;
      tick(); idle();
      check($sformatf("R2 vec%0d tx head", i), tx_data, VEC[i].eth);
      check($sformatf("R3 vec%0d tx empty", i), tx_empty, VEC[i].ete);
      check($sformatf("R4 vec%0d tx nempty", i), tx_nempty, VEC[i].etne);
      check($sformatf("R9 vec%0d rx head", i), rx_rdata, VEC[i].erh);
      check($sformatf("R3 vec%0d rx empty", i), rx_empty, VEC[i].ere);
      check($sformatf("R5 vec%0d rx nfull", i), rx_nfull, VEC[i].ernf);
    end

    // R3 fill tx to 15
    for (int i = 0; i < 15; i++) begin
      tx_wr = 1; tx_wdata = 8'h10 + 8'(i);
      tick(); idle();
      if (i == 13) check("R3 tx not full at 14", tx_full, 0);
    end
    check("R3 tx full at 15", tx_full, 1);
    check("R4 tx nempty at 15", tx_nempty, 0);
    // R6 overrun on full write
    tx_wr = 1; tx_wdata = 8'hEE; tick(); idle();
    check("R6 ovr set", tx_ovr, 1);
    check("R6 head kept", tx_data, 8'h10);
    // R10 full write with pop
    tx_wr = 1; tx_wdata = 8'hFF; tx_pop = 1; tick(); idle();
    check("R10 ovr still", tx_ovr, 1);
    check("R10 not full", tx_full, 0);
    check("R10 head moved", tx_data, 8'h11);
    for (int i = 0; i < 14; i++) begin
      check("R10 drain order", tx_data, 8'h11 + 8'(i));
      tx_pop = 1; tick(); idle();
    end
    check("R10 drained empty", tx_empty, 1);
    check("R6 ovr held", tx_ovr, 1);
    ovr_clr = 1; tick(); idle();
    check("R6 ovr cleared", tx_ovr, 0);

    // R4 threshold sweep
    tx_thr = 4'd3;
    for (int k = 0; k < 6; k++) begin
      check($sformatf("R4 count %0d", k), tx_nempty, (k <= 3) ? 1 : 0);
      tx_wr = 1; tx_wdata = 8'(k); tick(); idle();
    end
    for (int k = 0; k < 6; k++) begin tx_pop = 1; tick(); idle(); end
    check("R4 sweep drained", tx_empty, 1);

    // R5 threshold at maximum
    rx_thr = 4'd15;
    for (int k = 0; k < 15; k++) begin
      check($sformatf("R5 count %0d", k), rx_nfull, 0);
      rx_push = 1; rx_din = 8'h40 + 8'(k); tick(); idle();
    end
    check("R5 count 15", rx_nfull, 1);
    check("R3 rx full", rx_full, 1);
    rx_push = 1; rx_din = 8'h99; tick(); idle();
    check("R3 rx push dropped head", rx_rdata, 8'h40);
    for (int k = 0; k < 15; k++) begin
      check("R2 rx order", rx_rdata, 8'h40 + 8'(k));
      rx_rd = 1; tick(); idle();
    end
    check("R3 rx empty after drain", rx_empty, 1);
    tx_thr = 4'd1; rx_thr = 4'd2;

    // R7 R8 tx flush
    for (int k = 0; k < 3; k++) begin tx_wr = 1; tx_wdata = 8'hA0 + 8'(k); tick(); idle(); end
    for (int k = 0; k < 2; k++) begin rx_push = 1; rx_din = 8'hB0 + 8'(k); tick(); idle(); end
    ctrl_wr = 1; ctrl_wdata = 16'h0080; tick(); idle();
    check("R7 tx flush bit", ctrl_rdata, 16'h0080);
    for (int c = 1; c <= 4; c++) begin
      if (c == 1) begin tx_wr = 1; tx_wdata = 8'h77; tx_pop = 1; rx_rd = 1; end
      if (c == 2) begin ctrl_wr = 1; ctrl_wdata = 16'h0080; end
      tick(); idle();
      if (c < 4) begin
        check("R7 tx flush busy", ctrl_rdata, 16'h0080);
        check("R8 tx head frozen", tx_data, 8'hA0);
      end else begin
        check("R7 tx flush done", ctrl_rdata, 16'h0000);
        check("R7 tx empty", tx_empty, 1);
        check("R8 no ovr in flush", tx_ovr, 0);
      end
      if (c == 1) check("R8 rx unaffected", rx_rdata, 8'hB1);
    end

    // R7 R8 rx flush
    ctrl_wr = 1; ctrl_wdata = 16'h0100; tick(); idle();
    check("R7 rx flush bit", ctrl_rdata, 16'h0100);
    for (int c = 1; c <= 4; c++) begin
      if (c == 1) begin rx_push = 1; rx_din = 8'h55; rx_rd = 1; tx_wr = 1; tx_wdata = 8'h66; end
      tick(); idle();
      if (c < 4) begin
        check("R7 rx flush busy", ctrl_rdata, 16'h0100);
        check("R8 rx head frozen", rx_rdata, 8'hB1);
      end else begin
        check("R7 rx flush done", ctrl_rdata, 16'h0000);
        check("R7 rx empty", rx_empty, 1);
      end
    end
    check("R8 tx works in rx flush", tx_data, 8'h66);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule